// File: doc/BRIEF.md
# Clock Frequency Ratio Monitor

This block judges whether a fast external clock runs near its expected frequency, using a slow, independent reference clock as a common time base. A calibration pass counts cycles of the trusted internal clock across a window of reference periods and keeps that count as the stored reference. The same pass then counts cycles of the external clock across an equal window. The ratio of the two counts gives the external frequency in units of the internal one. The block compares that ratio with a nominal ratio and allows a ±25% band.

After calibration, each start strobe runs one runtime check. The check measures only the external clock and compares it against the stored internal count. The block runs no periodic timer of its own, so a system timer issues the start strobes at the desired rate. The result drives a request that selects the external clock. A failure pulls this request back to the internal clock in the same cycle the failure is reported. The startup check that closes a calibration always leaves the request on the internal clock.

Each counting domain receives the reference clock through its own synchroniser. Every command and every completion crosses between domains as a toggle. The window length and the nominal ratio are quasi-static inputs and must be held steady while a measurement runs.

Top module: `clkmon_ratio_top`

## Requirements
- R1: While reset is active and right after it, busy_o, done_o, pass_o, fail_o, cal_valid_o and sel_ext_o are all 0.
- R2: An accepted calib_i does two things. It counts internal cycles over win_edges_i reference periods and stores that count as the reference, setting cal_valid_o. It then runs an external check, reports pass or fail, and leaves sel_ext_o at 0 whatever the result.
- R3: An accepted start_i measures the external clock over win_edges_i reference periods and compares the result with the count stored at calibration, without measuring the internal clock again. A runtime window of 8 after a calibration window of 4 therefore fails at the nominal frequency.
- R4: A check passes when 0.75 ≤ (ext_count·nom_int_i)/(ref_count·nom_ext_i) ≤ 1.25, and fails otherwise.
- R5: A passing runtime check sets sel_ext_o to 1 (1 = external clock requested). A failing check sets sel_ext_o to 0 in the same cycle that fail_o rises.
- R6: done_o is a one-cycle pulse at the end of each check. busy_o is 1 from the cycle after an accepted strobe until the done pulse, and is 0 while done_o is 1.
- R7: pass_o and fail_o are never both 1. They hold their value until the next accepted strobe, which clears both.
- R8: A start_i with cal_valid_o at 0 reports fail_o with done_o in the cycle after the strobe and makes no measurement.
- R9: A start_i or calib_i that arrives while busy_o is 1 is ignored: the running check ends with exactly one done pulse and its own result.
- R10: When calib_i and start_i are both 1 in one idle cycle, the calibration is taken.
- R11: A check that has not completed within TIMEOUT_CYC internal cycles ends as a fail with sel_ext_o at 0. This covers a stopped external or reference clock. A later check completes normally once the clock runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Trusted internal clock; all control and status logic runs on it |
| clk_ext | input | 1 | Monitored external clock |
| clk_ref | input | 1 | Slow independent reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| start_i | input | 1 | Runtime check strobe, one clk_int cycle |
| calib_i | input | 1 | Calibration strobe, one clk_int cycle |
| win_edges_i | input | WIN_W | Window length in reference periods (0 is taken as 1) |
| nom_int_i | input | NOM_W | Nominal internal-frequency term of the expected ratio |
| nom_ext_i | input | NOM_W | Nominal external-frequency term of the expected ratio |
| busy_o | output | 1 | A check is in progress |
| done_o | output | 1 | One-cycle pulse when a check ends |
| pass_o | output | 1 | Sticky pass result |
| fail_o | output | 1 | Sticky fail result |
| cal_valid_o | output | 1 | A nonzero reference count is stored |
| sel_ext_o | output | 1 | Request to run from the external clock |

## Verification
The decision that ends a check and the update of the clock-select request fall in one cycle. The bench provokes this by following a passing runtime check with one whose external clock runs 37% slow. It then requires fail_o to rise in the same sampled cycle in which sel_ext_o returns to 0. A second collision comes from driving calib_i and start_i together in one idle cycle while the request is 1. That case is judged correct only if a single done pulse appears and the request ends at 0, which shows that the calibration path won.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

   typedef enum logic [1:0] {
      CTL_IDLE,
      CTL_CAL,
      CTL_EXT
   } ctl_state_e;

   typedef enum logic [1:0] {
      WIN_IDLE,
      WIN_ARM,
      WIN_RUN
   } win_phase_e;

endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   initial assert (STAGES >= 1) else $fatal(1, "clkmon_sync: STAGES must be at least 1");

   generate
      if (STAGES == 1) begin : g_single
         logic flop_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flop_q <= 1'b0;
            else        flop_q <= d_i;
         end
         assign q_o = flop_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_i};
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/clkmon_window.sv
module clkmon_window
   import clkmon_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int WIN_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_clk_i,
   input  logic             go_tgl_i,
   input  logic [WIN_W-1:0] win_i,
   output logic [CNT_W-1:0] count_o,
   output logic             done_tgl_o
);

   logic             go_s, ref_s, ref_q, go_q, done_q;
   logic [CNT_W-1:0] count_q;
   logic [WIN_W-1:0] edges_q;
   logic [WIN_W-1:0] win_eff;
   logic             ref_rise;
   win_phase_e       phase_q;

   clkmon_sync #(.STAGES(SYNC_STAGES)) u_go_sync (
      .clk(clk), .rst_n(rst_n), .d_i(go_tgl_i), .q_o(go_s));

   clkmon_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
      .clk(clk), .rst_n(rst_n), .d_i(ref_clk_i), .q_o(ref_s));

   assign ref_rise = ref_s & ~ref_q;
   assign win_eff  = (win_i == '0) ? WIN_W'(1) : win_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q   <= 1'b0;
         go_q    <= 1'b0;
         done_q  <= 1'b0;
         count_q <= '0;
         edges_q <= '0;
         phase_q <= WIN_IDLE;
      end else begin
         ref_q <= ref_s;
         if (go_s != go_q) begin
            go_q    <= go_s;
            done_q  <= ~go_s;
            count_q <= '0;
            edges_q <= '0;
            phase_q <= WIN_ARM;
         end else begin
            case (phase_q)
               WIN_ARM: if (ref_rise) phase_q <= WIN_RUN;
               WIN_RUN: begin
                  if (ref_rise && (edges_q == win_eff - WIN_W'(1))) begin
                     phase_q <= WIN_IDLE;
                     done_q  <= go_q;
                  end else begin
                     if (count_q != '1) count_q <= count_q + CNT_W'(1);
                     if (ref_rise) edges_q <= edges_q + WIN_W'(1);
                  end
               end
               default: phase_q <= WIN_IDLE;
            endcase
         end
      end
   end

   assign count_o    = count_q;
   assign done_tgl_o = done_q;

   // R3
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == WIN_IDLE && go_s == go_q) |=> $stable(count_q));

endmodule

// File: rtl/clkmon_judge.sv
module clkmon_judge #(
   parameter int CNT_W = 16,
   parameter int NOM_W = 8
) (
   input  logic [CNT_W-1:0] cnt_ref_i,
   input  logic [CNT_W-1:0] cnt_ext_i,
   input  logic [NOM_W-1:0] nom_int_i,
   input  logic [NOM_W-1:0] nom_ext_i,
   output logic             ok_o
);

   localparam int PROD_W = CNT_W + NOM_W + 3;

   logic [PROD_W-1:0] ext_term, ref_term, lhs, lo_bound, hi_bound;

   always_comb begin
      ext_term = PROD_W'(cnt_ext_i) * PROD_W'(nom_int_i);
      ref_term = PROD_W'(cnt_ref_i) * PROD_W'(nom_ext_i);
      lhs      = ext_term << 2;
      lo_bound = (ref_term << 1) + ref_term;
      hi_bound = (ref_term << 2) + ref_term;
      ok_o     = (lhs >= lo_bound) && (lhs <= hi_bound);
   end

endmodule

// File: rtl/clkmon_ratio_top.sv
module clkmon_ratio_top
   import clkmon_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int WIN_W       = 8,
   parameter int NOM_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int TIMEOUT_CYC = 4096
) (
   input  logic             clk_int,
   input  logic             clk_ext,
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             calib_i,
   input  logic [WIN_W-1:0] win_edges_i,
   input  logic [NOM_W-1:0] nom_int_i,
   input  logic [NOM_W-1:0] nom_ext_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             pass_o,
   output logic             fail_o,
   output logic             cal_valid_o,
   output logic             sel_ext_o
);

   localparam int TO_W = $clog2(TIMEOUT_CYC + 1);

   initial assert (CNT_W >= 4) else $fatal(1, "clkmon_ratio_top: CNT_W too small");
   initial assert (WIN_W >= 1) else $fatal(1, "clkmon_ratio_top: WIN_W too small");
   initial assert (NOM_W >= 1) else $fatal(1, "clkmon_ratio_top: NOM_W too small");
   initial assert (TIMEOUT_CYC >= 1) else $fatal(1, "clkmon_ratio_top: TIMEOUT_CYC too small");

   ctl_state_e       state_q;
   logic             go_int_q, go_ext_q, int_seen_q, ext_seen_q;
   logic             int_done_tgl, ext_done_tgl, ext_done_s;
   logic [CNT_W-1:0] cnt_int_w, cnt_ext_w, ref_cnt_q;
   logic [TO_W-1:0]  tmo_q;
   logic             cal_valid_q, startup_q, done_q, pass_q, fail_q, sel_q;
   logic             ratio_ok, int_fin, ext_fin, tmo_hit;

   clkmon_window #(.CNT_W(CNT_W), .WIN_W(WIN_W), .SYNC_STAGES(SYNC_STAGES)) u_win_int (
      .clk(clk_int), .rst_n(rst_n), .ref_clk_i(clk_ref), .go_tgl_i(go_int_q),
      .win_i(win_edges_i), .count_o(cnt_int_w), .done_tgl_o(int_done_tgl));

   clkmon_window #(.CNT_W(CNT_W), .WIN_W(WIN_W), .SYNC_STAGES(SYNC_STAGES)) u_win_ext (
      .clk(clk_ext), .rst_n(rst_n), .ref_clk_i(clk_ref), .go_tgl_i(go_ext_q),
      .win_i(win_edges_i), .count_o(cnt_ext_w), .done_tgl_o(ext_done_tgl));

   clkmon_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
      .clk(clk_int), .rst_n(rst_n), .d_i(ext_done_tgl), .q_o(ext_done_s));

   clkmon_judge #(.CNT_W(CNT_W), .NOM_W(NOM_W)) u_judge (
      .cnt_ref_i(ref_cnt_q), .cnt_ext_i(cnt_ext_w),
      .nom_int_i(nom_int_i), .nom_ext_i(nom_ext_i), .ok_o(ratio_ok));

   assign int_fin = int_seen_q && (int_done_tgl == go_int_q);
   assign ext_fin = ext_seen_q && (ext_done_s == go_ext_q);
   assign tmo_hit = (tmo_q == TO_W'(TIMEOUT_CYC));

   always_ff @(posedge clk_int or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= CTL_IDLE;
         go_int_q    <= 1'b0;
         go_ext_q    <= 1'b0;
         int_seen_q  <= 1'b0;
         ext_seen_q  <= 1'b0;
         ref_cnt_q   <= '0;
         tmo_q       <= '0;
         cal_valid_q <= 1'b0;
         startup_q   <= 1'b0;
         done_q      <= 1'b0;
         pass_q      <= 1'b0;
         fail_q      <= 1'b0;
         sel_q       <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            CTL_IDLE: begin
               if (calib_i) begin
                  go_int_q    <= ~go_int_q;
                  int_seen_q  <= 1'b0;
                  tmo_q       <= '0;
                  pass_q      <= 1'b0;
                  fail_q      <= 1'b0;
                  cal_valid_q <= 1'b0;
                  startup_q   <= 1'b1;
                  state_q     <= CTL_CAL;
               end else if (start_i) begin
                  pass_q    <= 1'b0;
                  startup_q <= 1'b0;
                  if (!cal_valid_q) begin
                     fail_q <= 1'b1;
                     done_q <= 1'b1;
                     sel_q  <= 1'b0;
                  end else begin
                     fail_q     <= 1'b0;
                     go_ext_q   <= ~go_ext_q;
                     ext_seen_q <= 1'b0;
                     tmo_q      <= '0;
                     state_q    <= CTL_EXT;
                  end
               end
            end
            CTL_CAL: begin
               if (int_done_tgl != go_int_q) int_seen_q <= 1'b1;
               if (int_fin) begin
                  ref_cnt_q   <= cnt_int_w;
                  cal_valid_q <= (cnt_int_w != '0);
                  go_ext_q    <= ~go_ext_q;
                  ext_seen_q  <= 1'b0;
                  tmo_q       <= '0;
                  state_q     <= CTL_EXT;
               end else if (tmo_hit) begin
                  fail_q  <= 1'b1;
                  done_q  <= 1'b1;
                  sel_q   <= 1'b0;
                  state_q <= CTL_IDLE;
               end else begin
                  tmo_q <= tmo_q + TO_W'(1);
               end
            end
            CTL_EXT: begin
               if (ext_done_s != go_ext_q) ext_seen_q <= 1'b1;
               if (ext_fin) begin
                  done_q  <= 1'b1;
                  pass_q  <= ratio_ok;
                  fail_q  <= ~ratio_ok;
                  sel_q   <= ratio_ok && !startup_q;
                  state_q <= CTL_IDLE;
               end else if (tmo_hit) begin
                  fail_q  <= 1'b1;
                  done_q  <= 1'b1;
                  sel_q   <= 1'b0;
                  state_q <= CTL_IDLE;
               end else begin
                  tmo_q <= tmo_q + TO_W'(1);
               end
            end
            default: state_q <= CTL_IDLE;
         endcase
      end
   end

   assign busy_o      = (state_q != CTL_IDLE);
   assign done_o      = done_q;
   assign pass_o      = pass_q;
   assign fail_o      = fail_q;
   assign cal_valid_o = cal_valid_q;
   assign sel_ext_o   = sel_q;

   // R7
   pass_fail_excl_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
      !(pass_o && fail_o));

   // R5
   fail_drops_sel_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
      $rose(fail_o) |-> !sel_ext_o);

   // R5
   sel_rise_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
      $rose(sel_ext_o) |-> (pass_o && done_o));

   // R6
   done_not_busy_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R6
   busy_entry_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
      $rose(busy_o) |-> $past(calib_i || start_i));

   // R7
   sticky_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
      (!start_i && !calib_i) |=> (done_o || ($stable(pass_o) && $stable(fail_o))));

   // R2
   startup_sel_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
      (done_o && startup_q) |-> !sel_ext_o);

endmodule

// File: tb/clkmon_ratio_top_bench.sv
`timescale 1ns/1ps
module clkmon_ratio_top_bench;

   localparam int WIN_W = 8;
   localparam int NOM_W = 8;
   localparam int N_VEC = 6;
   localparam int HALF_PS [N_VEC] = '{5000, 6000, 4250, 8000, 3500, 5000};
   localparam bit EXP_OK  [N_VEC] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

   logic clk_int = 1'b0, clk_ext = 1'b0, clk_ref = 1'b0, rst_n = 1'b0;
   logic start_i = 1'b0, calib_i = 1'b0;
   logic [WIN_W-1:0] win_edges_i = 8'd4;
   logic [NOM_W-1:0] nom_int_i = 8'd1, nom_ext_i = 8'd2;
   logic busy_o, done_o, pass_o, fail_o, cal_valid_o, sel_ext_o;

   real ext_half = 5.0;
   bit  ext_run  = 1'b1;
   int  checks = 0, errors = 0, done_cnt = 0;
   bit  seen;
   int  lat;

   always #10 clk_int = ~clk_int;
   always #200 clk_ref = ~clk_ref;
   always begin
      if (ext_run) begin
         #(ext_half);
         clk_ext = ~clk_ext;
      end else begin
         #1;
      end
   end

   clkmon_ratio_top u_clkmon_ratio_top (
      .clk_int(clk_int), .clk_ext(clk_ext), .clk_ref(clk_ref), .rst_n(rst_n),
      .start_i(start_i), .calib_i(calib_i), .win_edges_i(win_edges_i),
      .nom_int_i(nom_int_i), .nom_ext_i(nom_ext_i), .busy_o(busy_o),
      .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o),
      .cal_valid_o(cal_valid_o), .sel_ext_o(sel_ext_o));

   always @(negedge clk_int) if (done_o) done_cnt++;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic strobe(input bit do_start, input bit do_cal);
      @(negedge clk_int);
      start_i = do_start;
      calib_i = do_cal;
      @(posedge clk_int);
      #1;
      start_i = 1'b0;
      calib_i = 1'b0;
   endtask

   task automatic wait_done(output bit got, output int cycles);
      got = 1'b0;
      cycles = 0;
      for (int i = 0; i < 6000; i++) begin
         @(negedge clk_int);
         if (done_o) begin
            got = 1'b1;
            cycles = i;
            return;
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk_int);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk_int);
      // R1 reset state
      chk("R1", "busy in reset", busy_o, 0);
      chk("R1", "sel in reset", sel_ext_o, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk_int);
      chk("R1", "status after reset", {busy_o, done_o, pass_o, fail_o, cal_valid_o, sel_ext_o}, 0);

      // R8 start without calibration
      strobe(1'b1, 1'b0);
      wait_done(seen, lat);
      chk("R8", "done seen", seen, 1);
      chk("R8", "done latency", lat, 0);
      chk("R8", "fail", fail_o, 1);
      chk("R8", "pass", pass_o, 0);

      // R2 calibration with nominal external clock
      strobe(1'b0, 1'b1);
      @(negedge clk_int);
      chk("R6", "busy during calibration", busy_o, 1);
      chk("R7", "results cleared on accept", {pass_o, fail_o}, 0);
      wait_done(seen, lat);
      chk("R2", "done seen", seen, 1);
      chk("R2", "startup pass", pass_o, 1);
      chk("R2", "cal valid", cal_valid_o, 1);
      chk("R2", "startup leaves internal", sel_ext_o, 0);
      chk("R6", "busy low at done", busy_o, 0);
      @(negedge clk_int);
      chk("R6", "done one cycle", done_o, 0);
      repeat (40) @(negedge clk_int);
      chk("R7", "pass sticky", pass_o, 1);

      // R4 R5 vector table
      for (int v = 0; v < N_VEC; v++) begin
         ext_half = real'(HALF_PS[v]) / 1000.0;
         repeat (10) @(negedge clk_int);
         strobe(1'b1, 1'b0);
         wait_done(seen, lat);
         chk("R4", $sformatf("vec %0d done", v), seen, 1);
         chk("R4", $sformatf("vec %0d pass", v), pass_o, EXP_OK[v]);
         chk("R4", $sformatf("vec %0d fail", v), fail_o, !EXP_OK[v]);
         chk("R5", $sformatf("vec %0d sel", v), sel_ext_o, EXP_OK[v]);
      end
      ext_half = 5.0;
      repeat (10) @(negedge clk_int);

      // R9 strobes while busy are ignored
      begin
         int d0;
         d0 = done_cnt;
         strobe(1'b1, 1'b0);
         repeat (3) @(negedge clk_int);
         strobe(1'b0, 1'b1);
         strobe(1'b1, 1'b0);
         wait_done(seen, lat);
         repeat (300) @(negedge clk_int);
         chk("R9", "single done", done_cnt - d0, 1);
         chk("R9", "runtime result kept", sel_ext_o, 1);
      end

      // R10 calibrate and start together: calibration taken
      begin
         int d0;
         d0 = done_cnt;
         strobe(1'b1, 1'b1);
         wait_done(seen, lat);
         repeat (300) @(negedge clk_int);
         chk("R10", "one done", done_cnt - d0, 1);
         chk("R10", "sel back to internal", sel_ext_o, 0);
         chk("R10", "pass", pass_o, 1);
         chk("R10", "cal valid", cal_valid_o, 1);
      end

      // R3 stored reference reused: longer runtime window fails
      win_edges_i = 8'd8;
      strobe(1'b1, 1'b0);
      wait_done(seen, lat);
      chk("R3", "window mismatch fails", fail_o, 1);
      win_edges_i = 8'd4;
      strobe(1'b1, 1'b0);
      wait_done(seen, lat);
      chk("R3", "matching window passes", pass_o, 1);
      chk("R5", "sel after pass", sel_ext_o, 1);

      // R11 stopped external clock times out, then recovers
      ext_run = 1'b0;
      strobe(1'b1, 1'b0);
      wait_done(seen, lat);
      chk("R11", "timeout done", seen, 1);
      chk("R11", "timeout fail", fail_o, 1);
      chk("R11", "timeout sel", sel_ext_o, 0);
      ext_run = 1'b1;
      repeat (20) @(negedge clk_int);
      strobe(1'b1, 1'b0);
      wait_done(seen, lat);
      chk("R11", "recovery pass", pass_o, 1);
      chk("R11", "recovery sel", sel_ext_o, 1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule